// File: doc/BRIEF.md
# Seven-Tap Pipelined FIR Filter

This block is a direct-form finite impulse response filter. It filters a stream of signed 8-bit two's-complement samples with seven fixed signed coefficients. Every accepted sample enters a short delay line. All seven taps are multiplied by their constants at the same time, and the products are summed through a pipelined adder tree. The result is kept at full precision, so it is never rounded, saturated or wrapped.

A producer presents one sample per clock with a qualifying valid strobe. Results leave at the same rate, one per clock, after a constant pipeline delay. A matching valid strobe marks each result. Clocks with no valid sample do not advance the filter history, and they open a matching gap in the output stream.

Top module: `fir7_stream`

## Requirements
- R1: While `rst` is high at a rising edge, the filter history and all pipeline stages clear synchronously. After release, `outValid` is 0 and `outSum` is 0 until the first result arrives, and that result treats every older sample as zero.
- R2: Each result equals the sum over k = 0..6 of c[k]·x[n−k], where x[n] is the newest accepted sample. The coefficients are c[0..6] = 54, 64, −7, −16, 15, −3, −7, so c[0] weights the newest sample and c[6] the oldest.
- R3: `outSum` is an 18-bit signed full-precision value. Extreme inputs of −128 and +127, placed in sign-opposed patterns, give the exact arithmetic sum with no wrap. Its magnitude never exceeds 128·166.
- R4: A sample accepted at rising edge a (with `inValid` high) produces its result with `outValid` high in the cycle after edge a+2. That is three registered stages, counting the accepting edge.
- R5: Samples offered with `inValid` high on consecutive clocks each produce one result on consecutive clocks, in order, with no stall.
- R6: A clock with `inValid` low is ignored. The history does not shift, and `outValid` is low exactly three edges later. No result is produced for that clock.
- R7: While `outValid` is low, `outSum` keeps the value of the most recent result, or 0 after reset.
- R8: The first seven results after reset are computed with the not-yet-filled taps reading zero. An impulse of height h followed by zeros therefore yields h·c[0], h·c[1], …, h·c[6], and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inSample` in this cycle |
| inSample | input | 8 | Signed two's-complement input sample |
| outValid | output | 1 | Marks a new result on `outSum` |
| outSum | output | 18 | Signed full-precision filter output |

## Verification
A history register that shifted on an idle clock, or failed to shift on a valid one, would misalign every later result. The damage would appear at `outSum` within three cycles and persist until seven further valid samples have passed. A swapped or wrong coefficient would show on the first impulse result that reaches that tap. A truncated adder would show only on the extreme-value patterns. A valid-pipeline fault would surface at the ports as results arriving one edge early or late, or as phantom or missing results around idle gaps.

// File: rtl/fir7_pkg.sv
package fir7_pkg;

  localparam int COEF_W = 8;

  // Fixed coefficient set; index 0 weights the newest sample.
  function automatic logic signed [COEF_W-1:0] tapCoef(input int idx);
    case (idx)
      0:       tapCoef = 8'sd54;
      1:       tapCoef = 8'sd64;
      2:       tapCoef = -8'sd7;
      3:       tapCoef = -8'sd16;
      4:       tapCoef = 8'sd15;
      5:       tapCoef = -8'sd3;
      6:       tapCoef = -8'sd7;
      default: tapCoef = '0;
    endcase
  endfunction

  // Sum of absolute coefficient values, used for output range bounds.
  function automatic int coefAbsSum(input int taps);
    int acc;
    acc = 0;
    for (int i = 0; i < taps; i++) begin
      acc += (tapCoef(i) < 0) ? -int'(tapCoef(i)) : int'(tapCoef(i));
    end
    return acc;
  endfunction

  // Stage strobes from control to datapath.
  typedef struct packed {
    logic shiftEn;   // advance the history register
    logic mulEn;     // capture the product register
    logic partEn;    // capture the partial sums
    logic finEn;     // capture the final sum
  } firStrobe_t;

endpackage

// File: rtl/fir7_control.sv
module fir7_control
  import fir7_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output firStrobe_t stb,
  output logic       outValid
);

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[LAT-2:0], inValid};
    end
  end

  always_comb begin
    stb.shiftEn = inValid;
    stb.mulEn   = inValid;
    stb.partEn  = validPipe[0];
    stb.finEn   = validPipe[1];
  end

  assign outValid = validPipe[LAT-1];

endmodule

// File: rtl/fir7_datapath.sv
module fir7_datapath
  import fir7_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = 7,
  parameter int GROUP  = 3,
  parameter int SUM_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  firStrobe_t               stb,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [SUM_W-1:0]  outSum
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int NGROUP = (TAPS + GROUP - 1) / GROUP;

  logic signed [DATA_W-1:0] histQ  [TAPS-1];
  logic signed [DATA_W-1:0] window [TAPS];
  logic signed [PROD_W-1:0] prodQ  [TAPS];
  logic signed [SUM_W-1:0]  partD  [NGROUP];
  logic signed [SUM_W-1:0]  partQ  [NGROUP];
  logic signed [SUM_W-1:0]  finD;
  logic signed [SUM_W-1:0]  finQ;

  // Window: tap 0 is the incoming sample, higher taps are stored history.
  assign window[0] = inSample;
  for (genvar t = 1; t < TAPS; t++) begin : g_win
    assign window[t] = histQ[t-1];
  end

  // History register.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS-1; i++) histQ[i] <= '0;
    end else if (stb.shiftEn) begin
      histQ[0] <= inSample;
      for (int i = 1; i < TAPS-1; i++) histQ[i] <= histQ[i-1];
    end
  end

  // Constant multipliers, one per tap, registered.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CVAL = tapCoef(t);
    logic signed [PROD_W-1:0] prodNext;
    assign prodNext = window[t] * CVAL;
    always_ff @(posedge clk) begin
      if (rst) begin
        prodQ[t] <= '0;
      end else if (stb.mulEn) begin
        prodQ[t] <= prodNext;
      end
    end
  end

  // Partial-sum stage: groups of GROUP products.
  for (genvar g = 0; g < NGROUP; g++) begin : g_part
    always_comb begin
      partD[g] = '0;
      for (int j = 0; j < GROUP; j++) begin
        if (g * GROUP + j < TAPS) begin
          partD[g] = partD[g] + SUM_W'(prodQ[g*GROUP+j]);
        end
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        partQ[g] <= '0;
      end else if (stb.partEn) begin
        partQ[g] <= partD[g];
      end
    end
  end

  // Final-sum stage.
  always_comb begin
    finD = '0;
    for (int g = 0; g < NGROUP; g++) begin
      finD = finD + partQ[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      finQ <= '0;
    end else if (stb.finEn) begin
      finQ <= finD;
    end
  end

  assign outSum = finQ;

endmodule

// File: rtl/fir7_stream.sv
module fir7_stream
  import fir7_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = 7,
  parameter int GROUP  = 3,
  parameter int SUM_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [SUM_W-1:0]  outSum
);

  firStrobe_t stb;

  fir7_control #(
    .LAT (3)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  fir7_datapath #(
    .DATA_W (DATA_W),
    .TAPS   (TAPS),
    .GROUP  (GROUP),
    .SUM_W  (SUM_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .inSample (inSample),
    .outSum   (outSum)
  );

endmodule

// File: rtl/fir7_checker.sv
module fir7_checker
  import fir7_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = 7,
  parameter int SUM_W  = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inSample,
  input logic                     outValid,
  input logic signed [SUM_W-1:0]  outSum
);

  localparam int MAX_ABS = (1 << (DATA_W - 1)) * coefAbsSum(TAPS);

  // R1: just after reset release the output is quiet and zero
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && outSum == '0));

  // R4: an accepted sample yields a result three edges later
  a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid);

  // R6: an idle clock yields no result three edges later
  a_r6_no_phantom: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##3 !outValid);

  // R7: the output value is held while no result is marked
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSum));

  // R3: a result never exceeds the full-precision bound
  a_r3_sum_bound: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outSum) <= MAX_ABS && int'(outSum) >= -MAX_ABS));

  logic unusedSample;
  assign unusedSample = ^inSample;

endmodule

bind fir7_stream fir7_checker #(
  .DATA_W (DATA_W),
  .TAPS   (TAPS),
  .SUM_W  (SUM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inSample (inSample),
  .outValid (outValid),
  .outSum   (outSum)
);

// File: tb/fir7_stream_bench.sv
module fir7_stream_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NTAP = 7;
  localparam int COEF [NTAP] = '{54, 64, -7, -16, 15, -3, -7};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic signed [7:0] inSample = '0;
  logic              outValid;
  logic signed [17:0] outSum;

  fir7_stream u_fir7_stream (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inSample (inSample),
    .outValid (outValid),
    .outSum   (outSum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  int    edgeCount = 0;
  int    hist [NTAP];
  int    lastOut = 0;
  bit    monOn = 1'b0;
  int    expQ  [$];
  int    edgeQ [$];
  string tagQ  [$];

  always @(posedge clk) edgeCount <= edgeCount + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < NTAP; i++) hist[i] = 0;
    lastOut = 0;
  endtask

  // Driver: applies one clock of stimulus and pushes the expected result.
  task automatic drive(input bit v, input int s, input string tag);
    int acc;
    @(negedge clk);
    inValid  = v;
    inSample = 8'(s);
    if (v) begin
      for (int i = NTAP-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = s;
      acc = 0;
      for (int i = 0; i < NTAP; i++) acc += COEF[i] * hist[i];
      expQ.push_back(acc);
      edgeQ.push_back(edgeCount + 1 + 2);
      tagQ.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, "R6");
  endtask

  // Monitor: compares results as they appear, checks hold when idle.
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected result", int'(outSum), 0);
        end else begin
          int    e;
          int    eg;
          string tg;
          e  = expQ.pop_front();
          eg = edgeQ.pop_front();
          tg = tagQ.pop_front();
          check(int'(outSum) == e, {tg, "/R2 value"}, int'(outSum), e);
          check(edgeCount == eg, {tg, "/R4 latency edge"}, edgeCount, eg);
          lastOut = int'(outSum);
        end
      end else begin
        check(int'(outSum) == lastOut, "R7 hold while idle", int'(outSum), lastOut);
      end
    end
  end

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(outSum == '0, "R1 outSum in reset", int'(outSum), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after release", int'(outValid), 0);
    check(outSum == '0, "R1 outSum after release", int'(outSum), 0);
    monOn = 1'b1;

    // R8: impulse response through zero history
    drive(1'b1, 100, "R8");
    for (int i = 0; i < 8; i++) drive(1'b1, 0, "R8");
    idle(5);

    // R5: back-to-back ramp
    for (int i = 0; i < 20; i++) drive(1'b1, i * 13 - 120, "R5");
    idle(5);

    // R6: gapped stream, idle clocks must not shift history
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, (i * 37) % 200 - 100, "R6");
      if (i % 3 == 0) idle(1);
      if (i % 5 == 4) idle(3);
    end
    idle(5);

    // R3: extreme sign-opposed patterns
    drive(1'b1, 127, "R3"); drive(1'b1, 127, "R3"); drive(1'b1, -128, "R3");
    drive(1'b1, 127, "R3"); drive(1'b1, 127, "R3"); drive(1'b1, -128, "R3");
    drive(1'b1, -128, "R3");
    for (int i = 0; i < 7; i++) drive(1'b1, -128, "R3");
    drive(1'b1, -128, "R3"); drive(1'b1, -128, "R3"); drive(1'b1, 127, "R3");
    drive(1'b1, -128, "R3"); drive(1'b1, -128, "R3"); drive(1'b1, 127, "R3");
    drive(1'b1, 127, "R3");
    idle(5);

    // R1: mid-stream reset clears history
    for (int i = 0; i < 5; i++) drive(1'b1, 90 - i, "R5");
    idle(5);
    @(negedge clk);
    rst = 1'b1;
    clearModel();
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in second reset", int'(outValid), 0);
    rst = 1'b0;
    drive(1'b1, 1, "R1");
    drive(1'b1, 0, "R1");
    idle(6);

    check(expQ.size() == 0, "R4 results outstanding at end", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule